// File: doc/BRIEF.md
# Line Quality Statistics Unit

This unit watches the digitised output of one colour channel of a linear image sensor, one scan line at a time, and reduces each line to a handful of quality figures. Each incoming sample carries a valid strobe and a two-bit region code; only samples in the light-sensitive region take part. A line-end strobe closes the line. The unit then produces the mean level, the worst absolute deviation of any pixel from that mean, the non-uniformity as a percentage of the mean, and the imbalance between the odd and even pixel sets in percent.

No pixel is stored. While the line streams in, the unit keeps a pixel count, separate sums for odd and even positions, and the running minimum and maximum. At line end these are copied to a snapshot, the accumulators restart for the next line, and a post-processing sequencer runs one shared sequential divider three times over the snapshot. When every figure is settled the results are registered together and a one-cycle done pulse marks them. Typical use is calibration: dark lines give offset and dark non-uniformity, lines under flat illumination give response non-uniformity and staggered-pixel imbalance.

Top module: `line_stats`

## Requirements
- R1: After reset, `res_done` and `res_err` are low and all result outputs are zero.
- R2: A sample counts only when `in_vld` is 1 and `in_region` is 3 (active); region codes 0 (dummy), 1 (shielded) and 2 (edge), and cycles with `in_vld` low, have no effect on any result. `res_mean` is the floor of the sum of counted samples divided by their number.
- R3: `res_maxdev` equals the larger of (maximum counted sample minus `res_mean`) and (`res_mean` minus minimum counted sample).
- R4: `res_prnu` equals floor(`res_maxdev` × 100 / `res_mean`), and is 0 when `res_mean` is 0.
- R5: Counted samples are numbered from 1 in each line; odd numbers form the odd set. `res_imbal` is a two's-complement value equal to 200 × (odd sum − even sum) / (total sum), truncated toward zero, and 0 when the total sum is 0; it always lies in −200..200.
- R6: `res_count` equals the number of counted samples in the line.
- R7: A sample presented in the same cycle as `in_eol` belongs to the line being closed; the next line starts from empty accumulators.
- R8: A line closing with no counted samples gives a done pulse with `res_err` = 1 and every other result zero.
- R9: `res_done` is high for exactly one cycle per reported line, and all result outputs hold their values between done pulses.
- R10: A line end that arrives while the previous line is still being processed produces no result, and that line's samples do not leak into the following line.
- R11: A line of `MAX_PIX` full-scale samples is reported without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Sample strobe |
| in_data | input | DW | Sample value |
| in_region | input | 2 | Region code: 0 dummy, 1 shielded, 2 edge, 3 active |
| in_eol | input | 1 | Line end; the sample in this cycle, if any, is the last of the line |
| res_done | output | 1 | One-cycle pulse, results valid |
| res_err | output | 1 | Line had no counted samples |
| res_count | output | CNTW | Counted sample number |
| res_mean | output | DW | Floor of the line mean |
| res_maxdev | output | DW | Largest absolute deviation from the mean |
| res_prnu | output | PCTW | Non-uniformity in percent of the mean |
| res_imbal | output | 9 | Signed odd/even imbalance in percent |

## Verification
The embedded assertions watch every cycle for properties that follow from the arithmetic itself: the divider never restarts mid-operation and its remainder stays below the divisor, the mean always lies between the line's minimum and maximum, the running minimum never exceeds the maximum, the imbalance stays in its range, done is a single-cycle pulse and error reports carry zero results. Only the bench scenarios can show that the figures are numerically right for specific lines, that non-active regions and idle cycles are ignored, that a sample on the line-end cycle is included, that a line closed during processing is dropped without leaking, and that a full-length full-scale line does not overflow.

// File: rtl/line_stats_pkg.sv
package line_stats_pkg;

  typedef enum logic [1:0] {
    RGN_DUMMY  = 2'd0,
    RGN_SHIELD = 2'd1,
    RGN_EDGE   = 2'd2,
    RGN_ACTIVE = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_MEAN,
    S_DEV,
    S_PRNU,
    S_IMB,
    S_OUT
  } seq_state_e;

  localparam int IMB_SCALE  = 200;
  localparam int PCT_SCALE  = 100;
  localparam int IMBW       = 9;

endpackage

// File: rtl/lsu_accum.sv
module lsu_accum
  import line_stats_pkg::*;
#(
  parameter int DW      = 16,
  parameter int MAX_PIX = 21360,
  parameter int CNTW    = 15,
  parameter int SUMW    = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [DW-1:0]   in_data,
  input  logic [1:0]      in_region,
  input  logic            in_eol,
  input  logic            snap_en,
  output logic            snap_vld,
  output logic [CNTW-1:0] snap_cnt,
  output logic [SUMW-1:0] snap_so,
  output logic [SUMW-1:0] snap_se,
  output logic [DW-1:0]   snap_min,
  output logic [DW-1:0]   snap_max
);

  logic [CNTW-1:0] cnt_q, cnt_n, cnt_d;
  logic [SUMW-1:0] so_q, so_n, so_d;
  logic [SUMW-1:0] se_q, se_n, se_d;
  logic [DW-1:0]   mn_q, mn_n, mn_d;
  logic [DW-1:0]   mx_q, mx_n, mx_d;
  logic            take;
  logic            pos_odd;
  logic            load;

  assign take    = in_vld && (in_region == RGN_ACTIVE);
  assign pos_odd = ~cnt_q[0];
  assign load    = in_eol && snap_en && !snap_vld;

  // line values including the current sample
  always_comb begin
    cnt_n = cnt_q;
    so_n  = so_q;
    se_n  = se_q;
    mn_n  = mn_q;
    mx_n  = mx_q;
    if (take) begin
      cnt_n = cnt_q + 1'b1;
      if (pos_odd) so_n = so_q + SUMW'(in_data);
      else         se_n = se_q + SUMW'(in_data);
      if (in_data < mn_q) mn_n = in_data;
      if (in_data > mx_q) mx_n = in_data;
    end
  end

  // accumulator next state: restart on line end
  always_comb begin
    if (in_eol) begin
      cnt_d = '0;
      so_d  = '0;
      se_d  = '0;
      mn_d  = '1;
      mx_d  = '0;
    end else begin
      cnt_d = cnt_n;
      so_d  = so_n;
      se_d  = se_n;
      mn_d  = mn_n;
      mx_d  = mx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      so_q  <= '0;
      se_q  <= '0;
      mn_q  <= '1;
      mx_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      so_q  <= so_d;
      se_q  <= se_d;
      mn_q  <= mn_d;
      mx_q  <= mx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_vld <= 1'b0;
      snap_cnt <= '0;
      snap_so  <= '0;
      snap_se  <= '0;
      snap_min <= '0;
      snap_max <= '0;
    end else begin
      snap_vld <= load;
      if (load) begin
        snap_cnt <= cnt_n;
        snap_so  <= so_n;
        snap_se  <= se_n;
        snap_min <= mn_n;
        snap_max <= mx_n;
      end
    end
  end

  // R3: extremes stay ordered once a pixel has been seen
  a_r3_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (mn_q <= mx_q));

  // R11: line length stays within the sized range
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(MAX_PIX));

endmodule

// File: rtl/lsu_div.sv
module lsu_div #(
  parameter int NW  = 39,
  parameter int DVW = 31,
  localparam int CW = $clog2(NW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic [NW-1:0]  quotient
);

  logic [NW-1:0]  acc_q, acc_d;
  logic [DVW-1:0] rem_q, rem_d;
  logic [DVW-1:0] dvs_q, dvs_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           done_d;
  logic [DVW:0]   rem_sh;
  logic [DVW:0]   rem_sub;
  logic           fits;

  assign busy     = (cnt_q != '0);
  assign quotient = acc_q;

  assign rem_sh  = {rem_q, acc_q[NW-1]};
  assign rem_sub = rem_sh - {1'b0, dvs_q};
  assign fits    = (rem_sh >= {1'b0, dvs_q});

  always_comb begin
    acc_d  = acc_q;
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start) begin
      acc_d = dividend;
      rem_d = '0;
      dvs_d = divisor;
      cnt_d = CW'(NW);
    end else if (busy) begin
      acc_d  = {acc_q[NW-2:0], fits};
      rem_d  = fits ? rem_sub[DVW-1:0] : rem_sh[DVW-1:0];
      cnt_d  = cnt_q - 1'b1;
      done_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      rem_q <= rem_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
      done  <= done_d;
    end
  end

  // R2: a division is never restarted before it completes
  a_r2_div_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R2: partial remainder is always reduced below the divisor
  a_r2_div_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dvs_q != '0) |-> (rem_q < dvs_q));

endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
  import line_stats_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CNTW = 15,
  parameter int SUMW = 31,
  parameter int NW   = 39,
  parameter int PCTW = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   snap_vld,
  input  logic [CNTW-1:0]        snap_cnt,
  input  logic [SUMW-1:0]        snap_so,
  input  logic [SUMW-1:0]        snap_se,
  input  logic [DW-1:0]          snap_min,
  input  logic [DW-1:0]          snap_max,
  output logic                   idle,
  output logic                   div_start,
  output logic [NW-1:0]          div_dvd,
  output logic [SUMW-1:0]        div_dvs,
  input  logic                   div_done,
  input  logic [NW-1:0]          div_q,
  output logic                   res_done,
  output logic                   res_err,
  output logic [CNTW-1:0]        res_count,
  output logic [DW-1:0]          res_mean,
  output logic [DW-1:0]          res_maxdev,
  output logic [PCTW-1:0]        res_prnu,
  output logic signed [IMBW-1:0] res_imbal
);

  seq_state_e      st_q, st_d;
  logic            w_err_q, w_err_d;
  logic [DW-1:0]   w_mean_q, w_mean_d;
  logic [DW-1:0]   w_dev_q, w_dev_d;
  logic [PCTW-1:0] w_prnu_q, w_prnu_d;
  logic [IMBW-1:0] w_imb_q, w_imb_d;

  logic            done_d;
  logic            err_d;
  logic [CNTW-1:0] count_d;
  logic [DW-1:0]   mean_d;
  logic [DW-1:0]   dev_d;
  logic [PCTW-1:0] prnu_d;
  logic [IMBW-1:0] imb_d;

  logic [SUMW-1:0] total;
  logic [SUMW-1:0] diff_mag;
  logic            diff_neg;
  logic [DW-1:0]   up_dev;
  logic [DW-1:0]   dn_dev;
  logic [DW-1:0]   dev_now;
  logic [IMBW-1:0] q_imb;

  assign idle     = (st_q == S_IDLE);
  assign total    = snap_so + snap_se;
  assign diff_neg = (snap_so < snap_se);
  assign diff_mag = diff_neg ? (snap_se - snap_so) : (snap_so - snap_se);
  assign up_dev   = snap_max - w_mean_q;
  assign dn_dev   = w_mean_q - snap_min;
  assign dev_now  = (up_dev >= dn_dev) ? up_dev : dn_dev;
  assign q_imb    = div_q[IMBW-1:0];

  // next state and datapath control
  always_comb begin
    st_d      = st_q;
    w_err_d   = w_err_q;
    w_mean_d  = w_mean_q;
    w_dev_d   = w_dev_q;
    w_prnu_d  = w_prnu_q;
    w_imb_d   = w_imb_q;
    div_start = 1'b0;
    div_dvd   = '0;
    div_dvs   = '0;
    done_d    = 1'b0;
    err_d     = res_err;
    count_d   = res_count;
    mean_d    = res_mean;
    dev_d     = res_maxdev;
    prnu_d    = res_prnu;
    imb_d     = res_imbal;
    unique case (st_q)
      S_IDLE: begin
        if (snap_vld) begin
          w_mean_d = '0;
          w_dev_d  = '0;
          w_prnu_d = '0;
          w_imb_d  = '0;
          if (snap_cnt == '0) begin
            w_err_d = 1'b1;
            st_d    = S_OUT;
          end else begin
            w_err_d   = 1'b0;
            div_start = 1'b1;
            div_dvd   = NW'(total);
            div_dvs   = SUMW'(snap_cnt);
            st_d      = S_MEAN;
          end
        end
      end
      S_MEAN: begin
        if (div_done) begin
          w_mean_d = div_q[DW-1:0];
          st_d     = S_DEV;
        end
      end
      S_DEV: begin
        w_dev_d = dev_now;
        if (w_mean_q != '0) begin
          div_start = 1'b1;
          div_dvd   = NW'(dev_now) * NW'(PCT_SCALE);
          div_dvs   = SUMW'(w_mean_q);
          st_d      = S_PRNU;
        end else if (total != '0) begin
          div_start = 1'b1;
          div_dvd   = NW'(diff_mag) * NW'(IMB_SCALE);
          div_dvs   = total;
          st_d      = S_IMB;
        end else begin
          st_d = S_OUT;
        end
      end
      S_PRNU: begin
        if (div_done) begin
          w_prnu_d  = div_q[PCTW-1:0];
          div_start = 1'b1;
          div_dvd   = NW'(diff_mag) * NW'(IMB_SCALE);
          div_dvs   = total;
          st_d      = S_IMB;
        end
      end
      S_IMB: begin
        if (div_done) begin
          w_imb_d = diff_neg ? (~q_imb + 1'b1) : q_imb;
          st_d    = S_OUT;
        end
      end
      S_OUT: begin
        done_d  = 1'b1;
        err_d   = w_err_q;
        count_d = w_err_q ? '0 : snap_cnt;
        mean_d  = w_mean_q;
        dev_d   = w_dev_q;
        prnu_d  = w_prnu_q;
        imb_d   = w_imb_q;
        st_d    = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      w_err_q  <= 1'b0;
      w_mean_q <= '0;
      w_dev_q  <= '0;
      w_prnu_q <= '0;
      w_imb_q  <= '0;
    end else begin
      st_q     <= st_d;
      w_err_q  <= w_err_d;
      w_mean_q <= w_mean_d;
      w_dev_q  <= w_dev_d;
      w_prnu_q <= w_prnu_d;
      w_imb_q  <= w_imb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_done   <= 1'b0;
      res_err    <= 1'b0;
      res_count  <= '0;
      res_mean   <= '0;
      res_maxdev <= '0;
      res_prnu   <= '0;
      res_imbal  <= '0;
    end else begin
      res_done   <= done_d;
      res_err    <= err_d;
      res_count  <= count_d;
      res_mean   <= mean_d;
      res_maxdev <= dev_d;
      res_prnu   <= prnu_d;
      res_imbal  <= imb_d;
    end
  end

  // R3: the mean produced by the divider lies between the line extremes
  a_r3_mean_in_span: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DEV) |-> (w_mean_q >= snap_min && w_mean_q <= snap_max));

  // R4: every quotient fits the narrowest field that receives it
  a_r4_quot_fits: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (div_q[NW-1:PCTW] == '0));

  // R5: imbalance stays in its percent range
  a_r5_imbal_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (res_imbal >= -200 && res_imbal <= 200));

  // R8: error reports carry zero results
  a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_err) |-> (res_count == '0 && res_mean == '0 &&
                               res_maxdev == '0 && res_prnu == '0 && res_imbal == '0));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

endmodule

// File: rtl/line_stats.sv
module line_stats
  import line_stats_pkg::*;
#(
  parameter  int DW      = 16,
  parameter  int MAX_PIX = 21360,
  localparam int CNTW    = $clog2(MAX_PIX + 1),
  localparam int PCTW    = DW + 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld,
  input  logic [DW-1:0]          in_data,
  input  logic [1:0]             in_region,
  input  logic                   in_eol,
  output logic                   res_done,
  output logic                   res_err,
  output logic [CNTW-1:0]        res_count,
  output logic [DW-1:0]          res_mean,
  output logic [DW-1:0]          res_maxdev,
  output logic [PCTW-1:0]        res_prnu,
  output logic signed [IMBW-1:0] res_imbal
);

  localparam int SUMW = DW + CNTW;
  localparam int NW   = SUMW + 8;

  logic rst_meta;
  logic rst_s;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic            snap_en;
  logic            snap_vld;
  logic [CNTW-1:0] snap_cnt;
  logic [SUMW-1:0] snap_so;
  logic [SUMW-1:0] snap_se;
  logic [DW-1:0]   snap_min;
  logic [DW-1:0]   snap_max;
  logic            div_start;
  logic [NW-1:0]   div_dvd;
  logic [SUMW-1:0] div_dvs;
  logic            div_busy;
  logic            div_done;
  logic [NW-1:0]   div_q;

  lsu_accum #(
    .DW(DW), .MAX_PIX(MAX_PIX), .CNTW(CNTW), .SUMW(SUMW)
  ) u_accum (
    .clk(clk), .rst_n(rst_s),
    .in_vld(in_vld), .in_data(in_data), .in_region(in_region), .in_eol(in_eol),
    .snap_en(snap_en), .snap_vld(snap_vld), .snap_cnt(snap_cnt),
    .snap_so(snap_so), .snap_se(snap_se), .snap_min(snap_min), .snap_max(snap_max)
  );

  lsu_div #(
    .NW(NW), .DVW(SUMW)
  ) u_div (
    .clk(clk), .rst_n(rst_s),
    .start(div_start), .dividend(div_dvd), .divisor(div_dvs),
    .busy(div_busy), .done(div_done), .quotient(div_q)
  );

  lsu_seq #(
    .DW(DW), .CNTW(CNTW), .SUMW(SUMW), .NW(NW), .PCTW(PCTW)
  ) u_seq (
    .clk(clk), .rst_n(rst_s),
    .snap_vld(snap_vld), .snap_cnt(snap_cnt), .snap_so(snap_so), .snap_se(snap_se),
    .snap_min(snap_min), .snap_max(snap_max),
    .idle(snap_en),
    .div_start(div_start), .div_dvd(div_dvd), .div_dvs(div_dvs),
    .div_done(div_done), .div_q(div_q),
    .res_done(res_done), .res_err(res_err), .res_count(res_count),
    .res_mean(res_mean), .res_maxdev(res_maxdev), .res_prnu(res_prnu),
    .res_imbal(res_imbal)
  );

  // R10: the divider is idle whenever the sequencer accepts a new line
  a_r10_idle_div_free: assert property (@(posedge clk) disable iff (!rst_s)
    snap_en |-> !div_busy);

endmodule

// File: tb/line_stats_tb.sv
module line_stats_tb;

  localparam int DW      = 16;
  localparam int MAX_PIX = 21360;
  localparam int CNTW    = $clog2(MAX_PIX + 1);
  localparam int PCTW    = DW + 7;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_vld;
  logic [DW-1:0]        in_data;
  logic [1:0]           in_region;
  logic                 in_eol;
  logic                 res_done;
  logic                 res_err;
  logic [CNTW-1:0]      res_count;
  logic [DW-1:0]        res_mean;
  logic [DW-1:0]        res_maxdev;
  logic [PCTW-1:0]      res_prnu;
  logic signed [8:0]    res_imbal;

  always #2 clk = ~clk;

  line_stats #(.DW(DW), .MAX_PIX(MAX_PIX)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_vld(in_vld), .in_data(in_data), .in_region(in_region), .in_eol(in_eol),
    .res_done(res_done), .res_err(res_err), .res_count(res_count),
    .res_mean(res_mean), .res_maxdev(res_maxdev), .res_prnu(res_prnu),
    .res_imbal(res_imbal)
  );

  typedef struct {
    longint cnt, mean, dev, prnu, imb;
    bit     err;
  } exp_t;

  exp_t   sb[$];
  int     n_checks = 0;
  int     n_fail   = 0;
  bit     live     = 1'b0;
  bit     have_res = 1'b0;
  bit     prev_done = 1'b0;
  exp_t   last;
  longint m_cnt, m_so, m_se, m_min, m_max;
  longint cycles = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; m_so = 0; m_se = 0; m_min = 65535; m_max = 0;
  endtask

  task automatic px(int d, int r, bit eol, bit vld = 1'b1);
    @(negedge clk);
    in_vld = vld; in_data = DW'(d); in_region = 2'(r); in_eol = eol;
    if (vld && r == 3) begin
      if (m_cnt % 2 == 0) m_so += d; else m_se += d;
      m_cnt++;
      if (d < m_min) m_min = d;
      if (d > m_max) m_max = d;
    end
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0; in_eol = 1'b0; in_region = 2'd0; in_data = '0;
    end
  endtask

  // close the model line; push its expectation unless the line is to be dropped
  task automatic close_line(bit push);
    exp_t e;
    longint s, dm;
    s = m_so + m_se;
    e.err = (m_cnt == 0);
    e.cnt = m_cnt;
    e.mean = 0; e.dev = 0; e.prnu = 0; e.imb = 0;
    if (!e.err) begin
      e.mean = s / m_cnt;
      e.dev  = (m_max - e.mean > e.mean - m_min) ? m_max - e.mean : e.mean - m_min;
      e.prnu = (e.mean != 0) ? (e.dev * 100) / e.mean : 0;
      if (s != 0) begin
        dm = (m_so >= m_se) ? m_so - m_se : m_se - m_so;
        e.imb = (dm * 200) / s;
        if (m_so < m_se) e.imb = -e.imb;
      end
    end
    if (push) sb.push_back(e);
    model_clear();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (live) begin
      if (res_done) begin
        chk("R9", "done width", longint'(prev_done), 0);
        if (sb.size() == 0) begin
          chk("R10", "unexpected result", 1, 0);
        end else begin
          last = sb.pop_front();
          chk("R8", "err", longint'(res_err), longint'(last.err));
          chk("R6", "count", longint'(res_count), last.cnt);
          chk("R2", "mean", longint'(res_mean), last.mean);
          chk("R3", "maxdev", longint'(res_maxdev), last.dev);
          chk("R4", "prnu", longint'(res_prnu), last.prnu);
          chk("R5", "imbal", longint'(res_imbal), last.imb);
          have_res = 1'b1;
        end
      end else if (have_res) begin
        chk("R9", "held mean", longint'(res_mean), last.mean);
        chk("R9", "held imbal", longint'(res_imbal), last.imb);
      end
      prev_done = res_done;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired pending=%0d expected=0", sb.size());
      finish_run();
    end
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; in_vld = 1'b0; in_data = '0; in_region = 2'd0; in_eol = 1'b0;
    model_clear();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "done", longint'(res_done), 0);
    chk("R1", "err", longint'(res_err), 0);
    chk("R1", "mean", longint'(res_mean), 0);
    chk("R1", "prnu", longint'(res_prnu), 0);
    chk("R1", "imbal", longint'(res_imbal), 0);
    live = 1'b1;

    // R2: mixed regions, idle cycles inside; R7: last active sample on eol
    px(900, 0, 0); px(5, 1, 0); px(6, 1, 0); px(4000, 2, 0);
    px(100, 3, 0); px(120, 3, 0); px(7777, 3, 0, 1'b0); px(90, 3, 0);
    px(110, 3, 0); px(3000, 1, 0); px(105, 3, 0); px(95, 3, 0);
    px(130, 3, 0); px(80, 3, 1);
    close_line(1); quiet(200);

    // R4/R5: all-zero active line
    px(0, 3, 0); px(0, 3, 0); px(0, 3, 0); px(0, 3, 1);
    close_line(1); quiet(200);

    // R8: no active samples at all
    px(50, 1, 0); px(60, 2, 0); px(70, 0, 1);
    close_line(1); quiet(200);

    // R5: odd heavier, then even heavier
    for (int i = 0; i < 6; i++) px((i % 2 == 0) ? 200 : 100, 3, i == 5);
    close_line(1); quiet(200);
    for (int i = 0; i < 6; i++) px((i % 2 == 0) ? 100 : 300, 3, i == 5);
    close_line(1); quiet(200);

    // R4/R5 boundary: mean rounds to 0, imbalance at +200
    px(1, 3, 0); px(0, 3, 0); px(0, 3, 1);
    close_line(1); quiet(200);

    // R7: eol with no sample; line end alone after samples
    px(40, 3, 0); px(60, 3, 0); px(0, 0, 1, 1'b0);
    close_line(1); quiet(200);

    // R10: line closed during processing is dropped and does not leak
    px(500, 3, 0); px(700, 3, 0); px(300, 3, 1);
    close_line(1);
    px(9000, 3, 0); px(60000, 3, 0); px(1, 3, 1);
    close_line(0);
    quiet(200);
    px(20, 3, 0); px(30, 3, 1);
    close_line(1); quiet(200);

    // R2: pseudo-random line with mixed regions and strobes
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      px(int'(lf[11:0]) + 1000, int'(lf[13:12]) | (lf[14] ? 3 : 0), i == 599, lf[0] | lf[1]);
    end
    close_line(1); quiet(200);

    // R11: full-length full-scale line
    for (int i = 0; i < MAX_PIX; i++) px((i % 2 == 0) ? 65535 : 65534, 3, i == MAX_PIX - 1);
    close_line(1); quiet(200);

    // R10: every expected result arrived, nothing pending
    chk("R10", "pending results", longint'(sb.size()), 0);
    finish_run();
  end

endmodule